// File: doc/BRIEF.md
# Programmable Multi-Bank Clock Divider

This block sits behind a clock multiplier. It turns one fast source clock into three fanned-out banks of divided clocks and one separate feedback clock. The source is picked first. With `pll_on` high, the fast internal clock `vco_clk` drives the dividers. With `pll_on` low, the block runs in bypass and one of two reference clocks drives the dividers directly. `ref_sel` chooses which reference.

All dividers run on a single edge of the selected source clock. A shared prescaler divides that clock by 2 or by 4. Each bank then applies its own even ratio, so every output has an exact 50% duty cycle. All outputs start together on one source edge after the master reset is released.

The master reset `rst_n` is active low and asynchronous. It clears every divider and drops `out_drive`, the enable for the output pad drivers, which tri-states all clock pins at the pads. `out_en` forces the bank pins low but leaves the feedback clock running, so the loop can lock before clocks reach the rest of the chip. `out_en` is not synchronised, so the first pulse after it is released may be short. `cfg_bad` flags a loop-back choice whose total division from the source is below the stable minimum.

Top module: `mbclk_divnet`

## Requirements
- R1: `pre_sel` = 0 sets the prescale to 2 source cycles per tick, and `pre_sel` = 1 sets it to 4. Every output period in source cycles is the prescale times that output's own ratio.
- R2: Banks A and B each divide the prescaled clock by 2 when their select bit is 0 and by 4 when it is 1.
- R3: Bank C divides the prescaled clock by 4 when `c_sel` = 0 and by 6 when `c_sel` = 1.
- R4: The feedback clock divides the prescaled clock by 4, 6, 8 or 12 for `fb_sel` = 00, 01, 10 or 11.
- R5: Each output is high for exactly the first half of its period and low for the second half.
- R6: After `rst_n` rises, every output goes high on the (SYNC_STAGES+1)-th rising source edge (the third by default). From that edge on, each output rises every period.
- R7: While `rst_n` is low, all clock outputs are low and `out_drive` is low at once, without waiting for a clock edge. While `rst_n` is high, `out_drive` is high.
- R8: While `out_en` is low, all bank A, B and C pins are low. The feedback clock is unaffected and the bank dividers keep their phase, so the banks resume in step when `out_en` returns high.
- R9: With `pll_on` = 1 the dividers count `vco_clk` edges. With `pll_on` = 0 they count `ref0_clk` edges when `ref_sel` = 0 and `ref1_clk` edges when `ref_sel` = 1. Edges on clocks that are not selected have no effect.
- R10: `fb_route` names the output looped back to the phase detector: 00 feedback, 01 bank A, 10 bank B, 11 bank C. `cfg_bad` is high exactly when that output's total source division is below 8. With the default ratios this happens only when the prescale is 2 and the routed output is bank A or bank B set to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast internal source clock |
| ref0_clk | input | 1 | Reference clock 0 (bypass source) |
| ref1_clk | input | 1 | Reference clock 1 (bypass source) |
| ref_sel | input | 1 | Reference choice: 0 for ref0, 1 for ref1 |
| pll_on | input | 1 | 1 runs the dividers from vco_clk, 0 bypasses to the selected reference |
| rst_n | input | 1 | Asynchronous active-low master reset |
| out_en | input | 1 | 0 holds all bank pins low |
| pre_sel | input | 1 | Prescale choice: 0 for 2, 1 for 4 |
| a_sel | input | 1 | Bank A ratio: 0 for 2, 1 for 4 |
| b_sel | input | 1 | Bank B ratio: 0 for 2, 1 for 4 |
| c_sel | input | 1 | Bank C ratio: 0 for 4, 1 for 6 |
| fb_sel | input | 2 | Feedback ratio: 4, 6, 8, 12 |
| fb_route | input | 2 | Output looped back, used only for the validity flag |
| bank_a | output | NA | Bank A clock pins |
| bank_b | output | NB | Bank B clock pins |
| bank_c | output | NC | Bank C clock pins |
| fb_out | output | 1 | Feedback clock |
| out_drive | output | 1 | Pad driver enable; low tri-states every clock pin |
| cfg_bad | output | 1 | Loop-back division below the stable minimum |

## Verification
If the prescale phase or a bank counter went wrong, the effect would reach the pins within one output period. An edge would come one or more source cycles early or late, or a high phase would be too long or too short. The bench compares every pin with an independent edge-count model after every source edge, so the first wrong cycle is caught. A wrong source selection shows up as outputs that move in step with a clock that should be ignored; in the bench that unselected clock runs at a third of the rate. A divider that is disturbed by the output enable, or that keeps running through reset, shows up as a phase slip when the banks come back.

// File: rtl/mbclk_pkg.sv
package mbclk_pkg;

  localparam int RW = 4;
  typedef logic [RW-1:0] ratio_t;

  // divider slots; slot index equals the loop-back route code
  localparam int DIV_FB = 0;
  localparam int DIV_A  = 1;
  localparam int DIV_B  = 2;
  localparam int DIV_C  = 3;
  localparam int NDIV   = 4;

  function automatic ratio_t pre_ratio(input logic s);
    return s ? ratio_t'(4) : ratio_t'(2);
  endfunction

  function automatic ratio_t ab_ratio(input logic s);
    return s ? ratio_t'(4) : ratio_t'(2);
  endfunction

  function automatic ratio_t c_ratio(input logic s);
    return s ? ratio_t'(6) : ratio_t'(4);
  endfunction

  function automatic ratio_t fb_ratio(input logic [1:0] s);
    case (s)
      2'b00:   return ratio_t'(4);
      2'b01:   return ratio_t'(6);
      2'b10:   return ratio_t'(8);
      default: return ratio_t'(12);
    endcase
  endfunction

endpackage

// File: rtl/mbclk_srcsel.sv
module mbclk_srcsel (
  input  logic vco_clk,
  input  logic ref0_clk,
  input  logic ref1_clk,
  input  logic ref_sel,
  input  logic pll_on,
  output logic src_clk
);
  logic ref_clk;

  // R9: reference pick, then bypass pick
  assign ref_clk = ref_sel ? ref1_clk : ref0_clk;
  assign src_clk = pll_on ? vco_clk : ref_clk;
endmodule

// File: rtl/mbclk_rstsync.sv
module mbclk_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], 1'b1};
  end

  assign run = sh[STAGES-1];
endmodule

// File: rtl/mbclk_prescale.sv
module mbclk_prescale
  import mbclk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  ratio_t ratio,
  output logic   tick
);
  ratio_t pc;

  // R1: one tick every `ratio` source cycles, phase 0 on the first run edge
  assign tick = run && (pc >= ratio - ratio_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc <= '0;
    else if (!run) pc <= '0;
    else if (tick) pc <= '0;
    else           pc <= pc + ratio_t'(1);
  end
endmodule

// File: rtl/mbclk_bankdiv.sv
module mbclk_bankdiv
  import mbclk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  logic   tick,
  input  ratio_t ratio,
  output logic   q
);
  ratio_t k;
  ratio_t half;

  assign half = ratio >> 1;

  // R5: high while the tick count sits in the first half of the ratio
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k <= '0;
      q <= 1'b0;
    end else if (!run) begin
      k <= '0;
      q <= 1'b0;
    end else begin
      q <= (k < half);
      if (tick) k <= (k >= ratio - ratio_t'(1)) ? '0 : k + ratio_t'(1);
    end
  end
endmodule

// File: rtl/mbclk_divnet.sv
module mbclk_divnet
  import mbclk_pkg::*;
#(
  parameter int NA          = 5,
  parameter int NB          = 5,
  parameter int NC          = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_FB_DIV  = 8
) (
  input  logic          vco_clk,
  input  logic          ref0_clk,
  input  logic          ref1_clk,
  input  logic          ref_sel,
  input  logic          pll_on,
  input  logic          rst_n,
  input  logic          out_en,
  input  logic          pre_sel,
  input  logic          a_sel,
  input  logic          b_sel,
  input  logic          c_sel,
  input  logic [1:0]    fb_sel,
  input  logic [1:0]    fb_route,
  output logic [NA-1:0] bank_a,
  output logic [NB-1:0] bank_b,
  output logic [NC-1:0] bank_c,
  output logic          fb_out,
  output logic          out_drive,
  output logic          cfg_bad
);
  localparam int PW = 2 * RW;

  logic            src_clk;
  logic            run;
  logic            tick;
  ratio_t          pre_r;
  ratio_t          div_r [NDIV];
  logic [NDIV-1:0] q_raw;
  logic [PW-1:0]   route_div;

  mbclk_srcsel u_srcsel (
    .vco_clk  (vco_clk),
    .ref0_clk (ref0_clk),
    .ref1_clk (ref1_clk),
    .ref_sel  (ref_sel),
    .pll_on   (pll_on),
    .src_clk  (src_clk)
  );

  mbclk_rstsync #(.STAGES(SYNC_STAGES)) u_rstsync (
    .clk   (src_clk),
    .rst_n (rst_n),
    .run   (run)
  );

  always_comb begin
    pre_r         = pre_ratio(pre_sel);
    div_r[DIV_FB] = fb_ratio(fb_sel);
    div_r[DIV_A]  = ab_ratio(a_sel);
    div_r[DIV_B]  = ab_ratio(b_sel);
    div_r[DIV_C]  = c_ratio(c_sel);
  end

  mbclk_prescale u_pre (
    .clk   (src_clk),
    .rst_n (rst_n),
    .run   (run),
    .ratio (pre_r),
    .tick  (tick)
  );

  // R6: every divider shares run and tick, so all start on one edge
  for (genvar gi = 0; gi < NDIV; gi++) begin : g_div
    mbclk_bankdiv u_div (
      .clk   (src_clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick),
      .ratio (div_r[gi]),
      .q     (q_raw[gi])
    );
  end

  // R8: enable gates only the banks, never the feedback
  assign bank_a    = out_en ? {NA{q_raw[DIV_A]}} : '0;
  assign bank_b    = out_en ? {NB{q_raw[DIV_B]}} : '0;
  assign bank_c    = out_en ? {NC{q_raw[DIV_C]}} : '0;
  assign fb_out    = q_raw[DIV_FB];
  assign out_drive = rst_n;

  // R10: total division of the looped-back output
  assign route_div = PW'(pre_r) * PW'(div_r[fb_route]);
  assign cfg_bad   = route_div < PW'(MIN_FB_DIV);
endmodule

// File: rtl/mbclk_chk.sv
module mbclk_chk
  import mbclk_pkg::*;
#(
  parameter int NA = 5
) (
  input logic          src_clk,
  input logic          rst_n,
  input logic          out_en,
  input logic          pre_sel,
  input logic          a_sel,
  input logic [1:0]    fb_sel,
  input logic [1:0]    fb_route,
  input logic          q_fb,
  input logic          q_a,
  input logic [NA-1:0] bank_a,
  input logic          fb_out,
  input logic          out_drive,
  input logic          cfg_bad
);
  logic [7:0] fb_hi, a_hi, fb_half, a_half;

  always_comb begin
    fb_half = (8'(pre_ratio(pre_sel)) * 8'(fb_ratio(fb_sel))) >> 1;
    a_half  = (8'(pre_ratio(pre_sel)) * 8'(ab_ratio(a_sel))) >> 1;
  end

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_hi <= '0;
      a_hi  <= '0;
    end else begin
      fb_hi <= q_fb ? fb_hi + 8'd1 : 8'd0;
      a_hi  <= q_a  ? a_hi  + 8'd1 : 8'd0;
    end
  end

  // R4
  fb_high_time_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
    $fell(q_fb) |-> fb_hi == fb_half);

  // R2
  a_high_time_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
    $fell(q_a) |-> a_hi == a_half);

  // R8
  bank_gate_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
    !out_en |-> bank_a == '0);

  // R7
  reset_quiet_chk: assert property (@(posedge src_clk)
    !rst_n |-> (!fb_out && !out_drive && bank_a == '0));

  // R10
  route_flag_chk: assert property (@(posedge src_clk)
    cfg_bad |-> (fb_route == 2'b01 || fb_route == 2'b10));
endmodule

bind mbclk_divnet mbclk_chk #(.NA(NA)) u_chk (
  .src_clk   (src_clk),
  .rst_n     (rst_n),
  .out_en    (out_en),
  .pre_sel   (pre_sel),
  .a_sel     (a_sel),
  .fb_sel    (fb_sel),
  .fb_route  (fb_route),
  .q_fb      (q_raw[0]),
  .q_a       (q_raw[1]),
  .bank_a    (bank_a),
  .fb_out    (fb_out),
  .out_drive (out_drive),
  .cfg_bad   (cfg_bad)
);

// File: tb/test_mbclk_divnet.sv
module test_mbclk_divnet;
  localparam int NA = 5, NB = 5, NC = 4, SYNC = 2;

  logic tb_clk = 1'b0, junk_clk = 1'b0;
  int   mode = 0;
  logic ref_sel = 1'b0, pll_on = 1'b1, rst_n = 1'b0, out_en = 1'b1;
  logic pre_sel = 1'b0, a_sel = 1'b0, b_sel = 1'b0, c_sel = 1'b0;
  logic [1:0] fb_sel = 2'b00, fb_route = 2'b00;
  logic vco_clk, ref0_clk, ref1_clk;
  logic [NA-1:0] bank_a;
  logic [NB-1:0] bank_b;
  logic [NC-1:0] bank_c;
  logic fb_out, out_drive, cfg_bad;

  int vectors = 0, errors = 0;
  bit done = 1'b0;

  always #10 tb_clk = ~tb_clk;        // 50 MHz
  initial begin
    #5;
    forever #30 junk_clk = ~junk_clk; // edges never near tb_clk edges
  end

  assign vco_clk  = (mode == 0) ? tb_clk : junk_clk;
  assign ref0_clk = (mode == 1) ? tb_clk : junk_clk;
  assign ref1_clk = (mode == 2) ? tb_clk : junk_clk;

  mbclk_divnet #(.NA(NA), .NB(NB), .NC(NC), .SYNC_STAGES(SYNC)) i_mbclk_divnet (
    .vco_clk(vco_clk), .ref0_clk(ref0_clk), .ref1_clk(ref1_clk),
    .ref_sel(ref_sel), .pll_on(pll_on), .rst_n(rst_n), .out_en(out_en),
    .pre_sel(pre_sel), .a_sel(a_sel), .b_sel(b_sel), .c_sel(c_sel),
    .fb_sel(fb_sel), .fb_route(fb_route),
    .bank_a(bank_a), .bank_b(bank_b), .bank_c(bank_c),
    .fb_out(fb_out), .out_drive(out_drive), .cfg_bad(cfg_bad));

  function automatic logic mq(int n, int p, int m);
    if (n < 0) return 1'b0;
    return ((n / p) % m) < (m / 2);
  endfunction

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_cfg(int md, logic pre, logic a, logic b, logic c,
                         logic [1:0] fb, logic [1:0] route, int ncyc,
                         int oe_at, int oe_len);
    int p, ma, mb, mc, mf, mr, n, e;
    int ra, rf, xra, xrf;
    logic ea, eb, ec, ef, la, lf, lxa, lxf;
    p  = pre ? 4 : 2;
    ma = a ? 4 : 2;
    mb = b ? 4 : 2;
    mc = c ? 6 : 4;
    case (fb)
      2'b00: mf = 4;
      2'b01: mf = 6;
      2'b10: mf = 8;
      default: mf = 12;
    endcase
    case (route)
      2'b00: mr = mf;
      2'b01: mr = ma;
      2'b10: mr = mb;
      default: mr = mc;
    endcase
    @(negedge tb_clk);
    rst_n = 1'b0; out_en = 1'b1;
    mode = md; pll_on = (md == 0); ref_sel = (md == 2);
    pre_sel = pre; a_sel = a; b_sel = b; c_sel = c; fb_sel = fb; fb_route = route;
    repeat (2) @(negedge tb_clk);
    // R7 reset state
    chk("R7 reset bank_a", int'(bank_a), 0);
    chk("R7 reset fb_out", int'(fb_out), 0);
    chk("R7 reset out_drive", int'(out_drive), 0);
    // R10 flag
    chk("R10 cfg_bad", int'(cfg_bad), int'(p * mr < 8));
    rst_n = 1'b1;
    e = 0; ra = 0; rf = 0; xra = 0; xrf = 0;
    la = 0; lf = 0; lxa = 0; lxf = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(posedge tb_clk);
      e++;
      @(negedge tb_clk);
      n  = e - (SYNC + 1);             // R6 start edge
      ea = mq(n, p, ma) & out_en;      // R1 R2 R5 R8 R9
      eb = mq(n, p, mb) & out_en;
      ec = mq(n, p, mc) & out_en;
      ef = mq(n, p, mf);
      chk("R2 bank_a", int'(bank_a), ea ? (1 << NA) - 1 : 0);
      chk("R2 bank_b", int'(bank_b), eb ? (1 << NB) - 1 : 0);
      chk("R3 bank_c", int'(bank_c), ec ? (1 << NC) - 1 : 0);
      chk("R4 fb_out", int'(fb_out), int'(ef));
      chk("R7 out_drive", int'(out_drive), 1);
      if (fb_out && !lf) rf++;
      if (ef && !lxf) xrf++;
      if (bank_a[0] && !la) ra++;
      if (ea && !lxa) xra++;
      lf = fb_out; lxf = ef; la = bank_a[0]; lxa = ea;
      out_en = !(i >= oe_at && i < oe_at + oe_len);
    end
    // R1 rise counts give the frequency ratios between outputs
    chk("R1 fb rise count", rf, xrf);
    chk("R1 bank_a rise count", ra, xra);
    // R7 asynchronous entry, between edges
    #3 rst_n = 1'b0;
    #1;
    chk("R7 async bank_c", int'(bank_c), 0);
    chk("R7 async fb_out", int'(fb_out), 0);
    chk("R7 async out_drive", int'(out_drive), 0);
  endtask

  initial begin
    repeat (100000) @(posedge tb_clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R9 internal source; prescale 2, A/4 B/8 C/8 fb/8
    run_cfg(0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 100, 1000, 0);
    // R8 enable dropped mid-run, prescale 4, fb/48
    run_cfg(0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 2'b01, 160, 40, 23);
    // R9 bypass to ref0; R10 route A at 4 flagged
    run_cfg(1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 2'b01, 80, 1000, 0);
    // R9 bypass to ref1; R10 route B at 4 flagged
    run_cfg(2, 1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 2'b10, 80, 1000, 0);
    // R10 boundary: route A at total 8 is allowed
    run_cfg(0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b01, 60, 10, 1);
    // 6:3:2 spread A/2 B/4 C/6 (R3), fb/12
    run_cfg(0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 2'b11, 120, 1000, 0);
    // R10 route C never flagged; A and B both /4 for 1:1
    run_cfg(2, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 2'b11, 90, 1000, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule